// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus, made of a clock line and an open-drain data line. It receives frequency-programming bytes from a bus master and holds them in a bank of three byte latches. The serial clock and data inputs are oversampled in the system clock domain. The block drives the data line only by pulling it low through `sda_oe`. The first two latch bytes go out as parallel values to downstream synthesis logic. The third latch byte is reserved: it is stored and can be read back, but it has no output pin.

A write transfer has this shape: start, then the address byte with R/W = 0, then two dummy bytes that are discarded, then up to three latch bytes, then stop. A read transfer starts with the address byte with R/W = 1. The slave then returns the latches in order. Because the system clock oversamples the serial clock, it must run at least eight times faster than the serial clock.

The controller moves through these states:
- IDLE: it ignores the bus until a start condition.
- ADDR: it shifts in the address byte.
- ADDR_ACK: it pulls the line low when the address matches.
- WR_BYTE and WR_ACK: it receives each write byte and acknowledges it.
- RD_BYTE: it shifts a latch byte out, MSB first.
- RD_ACK: it samples the master's acknowledge.
- RD_WAIT: it waits for the falling clock edge after a master acknowledge, then loads the next byte.

A start condition in any state goes to ADDR. A stop condition in any state goes to IDLE. A mismatched address or a master not-acknowledge also goes to IDLE.

Top module: `cfg_serial_slave`

## Requirements
- R1: A stop condition (data rises while the clock is high) releases the data line: `sda_oe` is low from the next system clock and stays low while the bus is idle.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` (default 7'h52) is acknowledged by pulling the data line low during the ninth clock. The LSB of that byte is the direction bit: 0 means write, 1 means read.
- R3: An address byte that does not match gets no acknowledge. All further bytes up to the next start condition are also not acknowledged and change nothing.
- R4: In a write, the first two bytes after the address are dummies. They are acknowledged and not stored.
- R5: Write bytes three, four and five after the address go to latch 0, latch 1 and latch 2. Latch 0 drives `synth_p` and latch 1 drives `synth_q`. Latch 2 is reserved and can only be read back over the bus.
- R6: Write bytes after the fifth are acknowledged and leave all three latches unchanged.
- R7: Every write byte after a matching address is acknowledged by the slave.
- R8: A read returns latch 0, latch 1 and latch 2, MSB first, and then repeats latch 2 for every further byte.
- R9: A master not-acknowledge after a read byte makes the slave release the data line for the rest of the transfer.
- R10: A repeated start at any point restarts address reception and the dummy-byte count.
- R11: After reset all latches read zero, both outputs are zero and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line from the master |
| sda_i | input | 1 | Data line as seen on the bus |
| sda_oe | output | 1 | When high, the data line is pulled low |
| synth_p | output | 8 | Latch 0 contents |
| synth_q | output | 8 | Latch 1 contents |

## Verification
The in-RTL assertions check the following on every cycle:
- `sda_oe` is released after a stop and after a master not-acknowledge.
- A start always returns the controller to address reception with a cleared bit count.
- A mismatched address always sends the controller to IDLE.
- Every completed write byte is followed by an acknowledge.
- The latch bank only writes in range and otherwise holds its outputs.

Only the bench's scenarios can show the byte-level behaviour: which byte lands in which latch, that the dummy and excess bytes are discarded, the read order with the repeated last byte, and the effect of a repeated start partway through a write.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_RD_WAIT
    } cfgser_state_e;
endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // index STAGES-1 is the synchronized value, index STAGES its previous sample
    logic [STAGES:0] scl_ff;
    logic [STAGES:0] sda_ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-1:0], scl_i};
            sda_ff <= {sda_ff[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_prev, sda_prev;
    assign scl_now   = scl_ff[STAGES-1];
    assign scl_prev  = scl_ff[STAGES];
    assign sda_s     = sda_ff[STAGES-1];
    assign sda_prev  = sda_ff[STAGES];
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/cfgser_bank.sv
module cfgser_bank #(
    parameter int NUM_BYTES = 3,
    parameter int NUM_OUT   = 2,
    parameter int DW        = 8,
    localparam int IW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IW-1:0]         widx,
    input  logic [DW-1:0]         wdata,
    input  logic [IW-1:0]         ridx,
    output logic [DW-1:0]         rdata,
    output logic [NUM_OUT*DW-1:0] func_o
);
    logic [DW-1:0] mem [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_latch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && widx == IW'(g))
                mem[g] <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        assign func_o[g*DW +: DW] = mem[g];
    end

    assign rdata = (int'(ridx) < NUM_BYTES) ? mem[ridx] : '0;

    // R6
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> int'(widx) < NUM_BYTES);

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(func_o));
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfgser_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h52,
    parameter int         DUMMY_BYTES = 2,
    parameter int         NUM_BYTES   = 3,
    parameter int         DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [DW-1:0] synth_p,
    output logic [DW-1:0] synth_q
);
    localparam int LAST_SLOT = DUMMY_BYTES + NUM_BYTES;
    localparam int CW        = $clog2(LAST_SLOT + 1);
    localparam int BCW       = $clog2(DW + 1);
    localparam int IW        = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    cfgser_sync #(.STAGES(2)) u_sync (
        .clk, .rst_n, .scl_i, .sda_i,
        .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det
    );

    cfgser_state_e state;
    logic [DW-1:0]  shreg;
    logic [BCW-1:0] bit_cnt;
    logic [CW-1:0]  wr_cnt;
    logic [IW-1:0]  rd_idx;
    logic           rw_bit;
    logic           bank_we;
    logic [IW-1:0]  bank_widx;
    logic [DW-1:0]  bank_rdata;
    logic           byte_done;

    assign byte_done = scl_fall && (bit_cnt == BCW'(DW));

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            wr_cnt  <= '0;
            rd_idx  <= '0;
            rw_bit  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            wr_cnt  <= '0;
            rd_idx  <= '0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && bit_cnt < BCW'(DW)) begin
                        shreg   <= {shreg[DW-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg[DW-1:1] == DEV_ADDR) begin
                                state  <= ST_ADDR_ACK;
                                rw_bit <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            state <= ST_WR_ACK;
                            if (wr_cnt != CW'(LAST_SLOT))
                                wr_cnt <= wr_cnt + 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_bit) begin
                            state   <= ST_RD_BYTE;
                            shreg   <= bank_rdata;
                            bit_cnt <= '0;
                        end else begin
                            state <= ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall)
                        state <= ST_WR_BYTE;
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (bit_cnt == BCW'(DW - 1)) begin
                            state <= ST_RD_ACK;
                            if (int'(rd_idx) < NUM_BYTES - 1)
                                rd_idx <= rd_idx + 1'b1;
                        end else begin
                            shreg   <= {shreg[DW-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise)
                        state <= sda_s ? ST_IDLE : ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (scl_fall) begin
                        state   <= ST_RD_BYTE;
                        shreg   <= bank_rdata;
                        bit_cnt <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe    = 1'b0;
        bank_we   = 1'b0;
        bank_widx = IW'(wr_cnt - CW'(DUMMY_BYTES));
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~shreg[DW-1];
            ST_WR_BYTE:             bank_we = byte_done &&
                                        wr_cnt >= CW'(DUMMY_BYTES) &&
                                        wr_cnt <  CW'(LAST_SLOT);
            default: ;
        endcase
    end

    logic [2*DW-1:0] func_bytes;

    cfgser_bank #(.NUM_BYTES(NUM_BYTES), .NUM_OUT(2), .DW(DW)) u_bank (
        .clk, .rst_n,
        .we     (bank_we),
        .widx   (bank_widx),
        .wdata  (shreg),
        .ridx   (rd_idx),
        .rdata  (bank_rdata),
        .func_o (func_bytes)
    );

    assign synth_p = func_bytes[DW-1:0];
    assign synth_q = func_bytes[2*DW-1:DW];

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R10
    restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == '0));

    // R3
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_done && shreg[DW-1:1] != DEV_ADDR && !start_det && !stop_det)
        |=> (state == ST_IDLE && !sda_oe));

    // R7
    wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_BYTE && byte_done && !start_det && !stop_det) |=> sda_oe);

    // R9
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_rise && sda_s && !start_det && !stop_det) |=> !sda_oe);
endmodule

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [7:0] synth_p, synth_q;
    logic sda_line;
    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_p = 8'h00, exp_q = 8'h00, exp_r = 8'h00;

    assign sda_line = sda_m & ~sda_oe;
    always #5 clk = ~clk;

    cfg_serial_slave i_cfg_serial_slave (
        .clk, .rst_n, .scl_i(scl), .sda_i(sda_line),
        .sda_oe, .synth_p, .synth_q
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick();
        scl = 1'b1;   tick();
        sda_m = 1'b0; tick();
        scl = 1'b0;   tick();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick();
        scl = 1'b1;   tick();
        sda_m = 1'b1; tick();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick();
            scl = 1'b1; tick(); tick();
            scl = 1'b0;
        end
        sda_m = 1'b1; tick();
        scl = 1'b1; tick();
        acked = (sda_line == 1'b0);
        tick();
        scl = 1'b0;
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick();
            scl = 1'b1; tick();
            b[i] = sda_line;
            tick();
            scl = 1'b0;
        end
        sda_m = nack; tick();
        scl = 1'b1; tick(); tick();
        scl = 1'b0; tick();
        sda_m = 1'b1;
    endtask

    task automatic read_back(input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte(8'hA5, a);
        chk({req, "/R2 read addr ack"}, {7'd0, a}, 8'h01);
        get_byte(1'b0, b); chk({req, "/R8 byte0"}, b, exp_p);
        get_byte(1'b0, b); chk({req, "/R8 byte1"}, b, exp_q);
        get_byte(1'b0, b); chk({req, "/R8 byte2"}, b, exp_r);
        get_byte(1'b1, b); chk({req, "/R8 repeat byte2"}, b, exp_r);
        chk({req, "/R9 released after nack"}, {7'd0, sda_oe}, 8'h00);
        bus_stop();
        chk({req, "/R1 released after stop"}, {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic test_reset();
        chk("R11 oe", {7'd0, sda_oe}, 8'h00);
        chk("R11 p", synth_p, 8'h00);
        chk("R11 q", synth_q, 8'h00);
        read_back("R11");
    endtask

    task automatic test_full_write();
        logic a;
        bus_start();
        put_byte(8'hA4, a); chk("R2 write addr ack", {7'd0, a}, 8'h01);
        put_byte(8'hDE, a); chk("R4 dummy0 ack", {7'd0, a}, 8'h01);
        put_byte(8'hAD, a); chk("R4 dummy1 ack", {7'd0, a}, 8'h01);
        chk("R4 p untouched by dummies", synth_p, 8'h00);
        put_byte(8'h3C, a); chk("R7 latch0 ack", {7'd0, a}, 8'h01);
        put_byte(8'h81, a); chk("R7 latch1 ack", {7'd0, a}, 8'h01);
        put_byte(8'h5A, a); chk("R7 latch2 ack", {7'd0, a}, 8'h01);
        bus_stop();
        exp_p = 8'h3C; exp_q = 8'h81; exp_r = 8'h5A;
        chk("R5 p", synth_p, exp_p);
        chk("R5 q", synth_q, exp_q);
        read_back("R5");
    endtask

    task automatic test_extra_bytes();
        logic a;
        bus_start();
        put_byte(8'hA4, a);
        put_byte(8'h00, a); put_byte(8'h00, a);
        put_byte(8'h11, a); put_byte(8'h22, a); put_byte(8'h33, a);
        put_byte(8'hEE, a); chk("R6 extra ack", {7'd0, a}, 8'h01);
        put_byte(8'hFF, a); chk("R6 extra ack 2", {7'd0, a}, 8'h01);
        bus_stop();
        exp_p = 8'h11; exp_q = 8'h22; exp_r = 8'h33;
        chk("R6 p", synth_p, exp_p);
        chk("R6 q", synth_q, exp_q);
        read_back("R6");
    endtask

    task automatic test_wrong_addr();
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte(8'hA6, a); chk("R3 no addr ack", {7'd0, a}, 8'h00);
        put_byte(8'h00, a); chk("R3 no data ack", {7'd0, a}, 8'h00);
        put_byte(8'h00, a);
        put_byte(8'h99, a);
        bus_stop();
        chk("R3 p unchanged", synth_p, exp_p);
        bus_start();
        put_byte(8'hA7, a); chk("R3 no read ack", {7'd0, a}, 8'h00);
        get_byte(1'b1, b); chk("R3 line idle", b, 8'hFF);
        bus_stop();
    endtask

    task automatic test_restart();
        logic a;
        bus_start();
        put_byte(8'hA4, a);
        put_byte(8'h44, a);
        bus_start();
        put_byte(8'hA4, a); chk("R10 addr ack after restart", {7'd0, a}, 8'h01);
        put_byte(8'h55, a); put_byte(8'h66, a);
        put_byte(8'h77, a);
        bus_stop();
        exp_p = 8'h77;
        chk("R10 p", synth_p, exp_p);
        chk("R10 q unchanged", synth_q, exp_q);
        read_back("R10");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        test_reset();
        test_full_write();
        test_extra_bytes();
        test_wrong_addr();
        test_restart();
        finish_run();
    end
endmodule